// File: doc/BRIEF.md
# Serial Clock Source Selector

This block chooses the receive and transmit bit clocks of one serial channel. A 3-bit mode field routes one of several candidate sources to each direction. The candidates are an external receive clock pin, an external transmit clock pin, an oscillator tick, a recovered-clock strobe from a phase-locked sampler outside the block, and a divide-by-16 of an internal baud-rate divider. Every clock leaves the block as a single-cycle enable strobe in the system clock domain. No clock is gated.

The baud-rate divider counts oscillator ticks. It divides by 1 when a bypass bit is set, and otherwise by an even ratio 2·(k+1), where k is the factor field. Its output always feeds the clock-recovery reference, whatever mode is selected. The transmit clock pin can be turned into an output that carries the transmit clock, but only when the direction bit asks for it and the active mode does not take its transmit clock from that pin.

Top module: `clk_source_router`

## Requirements
- R1: The receive enable `rxClkEn` follows the synchronized receive pin in modes 0, 1 and 5. It follows `recClkEn` in modes 2, 3, 6 and 7, and `oscTick` in mode 4. Each source reaches the output one cycle after the source strobe.
- R2: The transmit enable `txClkEn` comes from a different source by mode:
  - the synchronized transmit pin in mode 0, and in modes 2 and 6 when `txAltSel`=0;
  - the synchronized receive pin in modes 1 and 5;
  - `recClkEn` in modes 3 and 7;
  - `oscTick` in mode 4.
- R3: In modes 2 and 6 with `txAltSel`=1, `txClkEn` pulses once for every 16 baud-divider output pulses.
- R4: The baud divider emits one pulse per `oscTick` when `brgBypass`=1. Otherwise it emits one pulse per 2·(`brgFactor`+1) ticks. It pulses only in the cycle after an `oscTick`.
- R5: `dpllRefEn` carries the baud-divider output in every mode.
- R6: Each rising edge on `rxClkPin` or `txClkPin` gives exactly one single-cycle enable, after a synchronizer of `SYNC_STAGES` flops.
- R7: `txPinOe` is 1 one cycle after `txPinIsOut`=1 while the mode does not use the transmit pin as a source. Under these rules the transmit pin is a source in mode 0, and in modes 2 and 6 when `txAltSel`=0. While `txPinOe` is set, `txPinOut` repeats `txClkEn`. Otherwise `txPinOut` is 0.
- R8: A change of `modeSel`, `brgBypass` or `brgFactor` reloads both divider counters at the next edge. No `dpllRefEn` pulse appears in the cycle after the change.
- R9: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Clock mode 0..7 |
| txAltSel | input | 1 | Modes 2 and 6: 1 selects the baud divider divided by 16 for transmit |
| txPinIsOut | input | 1 | Request to drive the transmit clock pin |
| brgBypass | input | 1 | Baud divider ratio of 1 |
| brgFactor | input | FACTOR_W | Divider factor k, ratio 2·(k+1) |
| rxClkPin | input | 1 | Asynchronous receive clock pin |
| txClkPin | input | 1 | Asynchronous transmit clock pin (input side) |
| recClkEn | input | 1 | Recovered clock strobe |
| oscTick | input | 1 | Oscillator clock strobe |
| rxClkEn | output | 1 | Receive bit clock enable |
| txClkEn | output | 1 | Transmit bit clock enable |
| dpllRefEn | output | 1 | Baud-divider reference to clock recovery |
| txPinOe | output | 1 | Transmit pin output enable |
| txPinOut | output | 1 | Transmit pin drive value |

## Verification
The bench builds the block with `FACTOR_W`=4 and `SYNC_STAGES`=2. With these values, the full-scale ratio of 32 and its divide-by-16 period of 1024 cycles both fit inside a single 1024-cycle count window. Every source rate is a divisor of that window, so each mode gives exact pulse counts whatever the phase. These counts tell the pin, recovered, oscillator and divider sources apart. Back-to-back configuration writes then exercise the reload at both phases of the oscillator tick.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  // Candidate sources; the value is the bit index into the source vector.
  typedef enum logic [2:0] {
    SRC_RXPIN = 3'd0,
    SRC_TXPIN = 3'd1,
    SRC_REC   = 3'd2,
    SRC_OSC   = 3'd3,
    SRC_DIV16 = 3'd4
  } clkSrc_e;

  localparam int NUM_SRC = 5;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    reload;
    clkSrc_e rxSel;
    clkSrc_e txSel;
    logic    txDrive;
  } selStrobe_t;

endpackage

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int FACTOR_W = 10
) (
  input  logic                clk,
  input  logic [2:0]          modeSel,
  input  logic                txAltSel,
  input  logic                txPinIsOut,
  input  logic                brgBypass,
  input  logic [FACTOR_W-1:0] brgFactor,
  output selStrobe_t          strobes
);

  localparam int CFG_W = 3 + 1 + FACTOR_W;

  logic [CFG_W-1:0] cfgNow;
  logic [CFG_W-1:0] cfgPrev;
  logic             pinIsSource;

  assign cfgNow = {modeSel, brgBypass, brgFactor};

  // Tracks the configuration through reset as well, so that the first
  // compare after reset sees the previous cycle's setting.
  always_ff @(posedge clk) begin
    cfgPrev <= cfgNow;
  end

  always_comb begin
    strobes.rxSel = SRC_RXPIN;
    strobes.txSel = SRC_TXPIN;
    pinIsSource   = 1'b0;
    case (modeSel)
      3'd0: begin
        strobes.rxSel = SRC_RXPIN;
        strobes.txSel = SRC_TXPIN;
        pinIsSource   = 1'b1;
      end
      3'd1, 3'd5: begin
        strobes.rxSel = SRC_RXPIN;
        strobes.txSel = SRC_RXPIN;
      end
      3'd2, 3'd6: begin
        strobes.rxSel = SRC_REC;
        strobes.txSel = txAltSel ? SRC_DIV16 : SRC_TXPIN;
        pinIsSource   = ~txAltSel;
      end
      3'd3, 3'd7: begin
        strobes.rxSel = SRC_REC;
        strobes.txSel = SRC_REC;
      end
      default: begin
        strobes.rxSel = SRC_OSC;
        strobes.txSel = SRC_OSC;
      end
    endcase
    strobes.txDrive = txPinIsOut & ~pinIsSource;
    strobes.reload  = (cfgNow != cfgPrev);
  end

endmodule

// File: rtl/clksel_datapath.sv
module clksel_datapath
  import clksel_pkg::*;
#(
  parameter int FACTOR_W    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  selStrobe_t          strobes,
  input  logic                brgBypass,
  input  logic [FACTOR_W-1:0] brgFactor,
  input  logic                rxClkPin,
  input  logic                txClkPin,
  input  logic                recClkEn,
  input  logic                oscTick,
  output logic                rxClkEn,
  output logic                txClkEn,
  output logic                brgOutEn,
  output logic                txPinOe,
  output logic                txPinOut
);

  localparam int CNT_W  = FACTOR_W + 1;
  localparam int DIV16  = 16;
  localparam int D16_W  = $clog2(DIV16);
  localparam int NUM_PIN = 2;

  logic [NUM_PIN-1:0] pinRaw;
  logic [NUM_PIN-1:0] pinEdge;

  assign pinRaw = {txClkPin, rxClkPin};

  // Synchronizer and rising-edge detect per pin.
  for (genvar g = 0; g < NUM_PIN; g++) begin : gPin
    logic [SYNC_STAGES:0] syncChain;
    always_ff @(posedge clk) begin
      if (!rstN) syncChain <= '0;
      else       syncChain <= {syncChain[SYNC_STAGES-1:0], pinRaw[g]};
    end
    assign pinEdge[g] = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];
  end

  // Baud-rate divider: terminal count = ratio - 1.
  logic [CNT_W-1:0] brgLimit;
  logic [CNT_W-1:0] brgCnt;
  logic [D16_W-1:0] d16Cnt;
  logic             div16En;

  assign brgLimit = brgBypass ? '0 : {brgFactor, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brgCnt   <= '0;
      brgOutEn <= 1'b0;
    end else if (strobes.reload) begin
      brgCnt   <= brgLimit;
      brgOutEn <= 1'b0;
    end else if (oscTick) begin
      if (brgCnt == '0) begin
        brgCnt   <= brgLimit;
        brgOutEn <= 1'b1;
      end else begin
        brgCnt   <= brgCnt - 1'b1;
        brgOutEn <= 1'b0;
      end
    end else begin
      brgOutEn <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      d16Cnt  <= '0;
      div16En <= 1'b0;
    end else if (strobes.reload) begin
      d16Cnt  <= D16_W'(DIV16 - 1);
      div16En <= 1'b0;
    end else if (brgOutEn) begin
      if (d16Cnt == '0) begin
        d16Cnt  <= D16_W'(DIV16 - 1);
        div16En <= 1'b1;
      end else begin
        d16Cnt  <= d16Cnt - 1'b1;
        div16En <= 1'b0;
      end
    end else begin
      div16En <= 1'b0;
    end
  end

  // Source vector indexed by clkSrc_e.
  logic [NUM_SRC-1:0] srcVec;
  logic               rxPick;
  logic               txPick;

  assign srcVec = {div16En, oscTick, recClkEn, pinEdge[1], pinEdge[0]};
  assign rxPick = srcVec[strobes.rxSel];
  assign txPick = srcVec[strobes.txSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxClkEn  <= 1'b0;
      txClkEn  <= 1'b0;
      txPinOe  <= 1'b0;
      txPinOut <= 1'b0;
    end else begin
      rxClkEn  <= rxPick;
      txClkEn  <= txPick;
      txPinOe  <= strobes.txDrive;
      txPinOut <= strobes.txDrive & txPick;
    end
  end

endmodule

// File: rtl/clk_source_router.sv
module clk_source_router
  import clksel_pkg::*;
#(
  parameter int FACTOR_W    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          modeSel,
  input  logic                txAltSel,
  input  logic                txPinIsOut,
  input  logic                brgBypass,
  input  logic [FACTOR_W-1:0] brgFactor,
  input  logic                rxClkPin,
  input  logic                txClkPin,
  input  logic                recClkEn,
  input  logic                oscTick,
  output logic                rxClkEn,
  output logic                txClkEn,
  output logic                dpllRefEn,
  output logic                txPinOe,
  output logic                txPinOut
);

  selStrobe_t strobes;

  clksel_ctrl #(.FACTOR_W(FACTOR_W)) u_ctrl (
    .clk        (clk),
    .modeSel    (modeSel),
    .txAltSel   (txAltSel),
    .txPinIsOut (txPinIsOut),
    .brgBypass  (brgBypass),
    .brgFactor  (brgFactor),
    .strobes    (strobes)
  );

  clksel_datapath #(.FACTOR_W(FACTOR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .brgBypass (brgBypass),
    .brgFactor (brgFactor),
    .rxClkPin  (rxClkPin),
    .txClkPin  (txClkPin),
    .recClkEn  (recClkEn),
    .oscTick   (oscTick),
    .rxClkEn   (rxClkEn),
    .txClkEn   (txClkEn),
    .brgOutEn  (dpllRefEn),
    .txPinOe   (txPinOe),
    .txPinOut  (txPinOut)
  );

endmodule

// File: rtl/clksel_checker.sv
module clksel_checker #(
  parameter int FACTOR_W = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          modeSel,
  input logic                txAltSel,
  input logic                txPinIsOut,
  input logic                brgBypass,
  input logic [FACTOR_W-1:0] brgFactor,
  input logic                oscTick,
  input logic                rxClkEn,
  input logic                dpllRefEn,
  input logic                txPinOe
);

  assert_oe_needs_dir_R7: assert property (@(posedge clk) disable iff (!rstN)
    txPinOe |-> $past(txPinIsOut));

  assert_oe_pin_free_R7: assert property (@(posedge clk) disable iff (!rstN)
    txPinOe |-> !(($past(modeSel) == 3'd0) ||
                  ((($past(modeSel) == 3'd2) || ($past(modeSel) == 3'd6)) && !$past(txAltSel))));

  assert_ref_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    dpllRefEn |-> $past(oscTick));

  assert_reload_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ({modeSel, brgBypass, brgFactor} != $past({modeSel, brgBypass, brgFactor})) |=> !dpllRefEn);

  assert_osc_rx_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rxClkEn && ($past(modeSel) == 3'd4)) |-> $past(oscTick));

endmodule

bind clk_source_router clksel_checker #(.FACTOR_W(FACTOR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .txAltSel   (txAltSel),
  .txPinIsOut (txPinIsOut),
  .brgBypass  (brgBypass),
  .brgFactor  (brgFactor),
  .oscTick    (oscTick),
  .rxClkEn    (rxClkEn),
  .dpllRefEn  (dpllRefEn),
  .txPinOe    (txPinOe)
);

// File: tb/sim_clk_source_router.sv
`timescale 1ns/1ps
module sim_clk_source_router;

  localparam int FW  = 4;
  localparam int WIN = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic txAltSel = 1'b0, txPinIsOut = 1'b0, brgBypass = 1'b0;
  logic [FW-1:0] brgFactor = '0;
  logic rxClkPin = 1'b0, txClkPin = 1'b0, recClkEn = 1'b0, oscTick = 1'b0;
  logic rxClkEn, txClkEn, dpllRefEn, txPinOe, txPinOut;

  always #4 clk = ~clk;

  clk_source_router #(.FACTOR_W(FW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .txAltSel(txAltSel),
    .txPinIsOut(txPinIsOut), .brgBypass(brgBypass), .brgFactor(brgFactor),
    .rxClkPin(rxClkPin), .txClkPin(txClkPin), .recClkEn(recClkEn),
    .oscTick(oscTick), .rxClkEn(rxClkEn), .txClkEn(txClkEn),
    .dpllRefEn(dpllRefEn), .txPinOe(txPinOe), .txPinOut(txPinOut)
  );

  int nChecks = 0, nFail = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Free-running stimulus: rx pin period 8, tx pin 16, recovered 4, osc 2.
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    rxClkPin <= (cyc % 8) < 4;
    txClkPin <= (cyc % 16) < 8;
    recClkEn <= (cyc % 4) == 1;
    oscTick  <= (cyc % 2) == 0;
  end

  // Pulse counters, sampled away from the active edge.
  int winLeft = 0;
  int cRx, cTx, cRef, cPin, cDouble;
  logic prevRx = 1'b0;
  always @(posedge clk) begin
    #2;
    if (winLeft > 0) begin
      cRx  += int'(rxClkEn);
      cTx  += int'(txClkEn);
      cRef += int'(dpllRefEn);
      cPin += int'(txPinOut);
      if (rxClkEn && prevRx) cDouble++;
      winLeft--;
    end
    prevRx = rxClkEn;
  end

  typedef struct packed {
    logic [2:0]    m;
    logic          alt;
    logic          isOut;
    logic          byp;
    logic [FW-1:0] k;
    logic [11:0]   eRx;
    logic [11:0]   eTx;
    logic [11:0]   eRef;
    logic [11:0]   ePin;
    logic          eOe;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 1'b1, 1'b1, 4'd0,  12'd128, 12'd64,  12'd512, 12'd0,   1'b0},
    '{3'd1, 1'b0, 1'b1, 1'b0, 4'd0,  12'd128, 12'd128, 12'd256, 12'd128, 1'b1},
    '{3'd2, 1'b0, 1'b1, 1'b0, 4'd3,  12'd256, 12'd64,  12'd64,  12'd0,   1'b0},
    '{3'd2, 1'b1, 1'b1, 1'b0, 4'd3,  12'd256, 12'd4,   12'd64,  12'd4,   1'b1},
    '{3'd3, 1'b0, 1'b1, 1'b0, 4'd0,  12'd256, 12'd256, 12'd256, 12'd256, 1'b1},
    '{3'd4, 1'b0, 1'b1, 1'b1, 4'd0,  12'd512, 12'd512, 12'd512, 12'd512, 1'b1},
    '{3'd5, 1'b0, 1'b0, 1'b0, 4'd1,  12'd128, 12'd128, 12'd128, 12'd0,   1'b0},
    '{3'd6, 1'b1, 1'b1, 1'b1, 4'd0,  12'd256, 12'd32,  12'd512, 12'd32,  1'b1},
    '{3'd6, 1'b0, 1'b1, 1'b0, 4'd1,  12'd256, 12'd64,  12'd128, 12'd0,   1'b0},
    '{3'd7, 1'b0, 1'b1, 1'b0, 4'd15, 12'd256, 12'd256, 12'd16,  12'd256, 1'b1},
    '{3'd2, 1'b1, 1'b1, 1'b0, 4'd15, 12'd256, 12'd1,   12'd16,  12'd1,   1'b1}
  };

  initial begin
    #(200000 * 8);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R9: outputs quiet under reset
    repeat (6) @(negedge clk);
    check("R9 reset outputs", int'({rxClkEn, txClkEn, dpllRefEn, txPinOe, txPinOut}), 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      modeSel = VEC[v].m; txAltSel = VEC[v].alt; txPinIsOut = VEC[v].isOut;
      brgBypass = VEC[v].byp; brgFactor = VEC[v].k;
      repeat (40) @(negedge clk);
      cRx = 0; cTx = 0; cRef = 0; cPin = 0; cDouble = 0;
      winLeft = WIN;
      wait (winLeft == 0);
      @(negedge clk);
      check($sformatf("R1 rx count v%0d", v), cRx, int'(VEC[v].eRx));
      check($sformatf("R2/R3 tx count v%0d", v), cTx, int'(VEC[v].eTx));
      check($sformatf("R4/R5 ref count v%0d", v), cRef, int'(VEC[v].eRef));
      check($sformatf("R7 pin out count v%0d", v), cPin, int'(VEC[v].ePin));
      check($sformatf("R7 pin oe v%0d", v), int'(txPinOe), int'(VEC[v].eOe));
      if (v == 0) check("R6 single-cycle rx enable", cDouble, 0);
    end

    // R8: back-to-back config writes, divider must stay quiet after each
    modeSel = 3'd4; brgBypass = 1'b1; brgFactor = '0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      brgFactor = brgFactor + 1'b1;
      @(negedge clk);
      check("R8 no ref pulse after change", int'(dpllRefEn), 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule